// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits between a set of interrupt sources and a processor core and decides which source the core should service next. Every source owns a pending latch, an enable bit and a handler vector. The lowest-numbered source that is latched, enabled and not already being serviced wins. The block then raises a request to the core and presents that source's index and vector.

The core confirms the request with an acknowledge, which marks the source as in service. It ends the handler with a return-from-interrupt pulse. A global mode bit selects the servicing style. With nesting off, nothing new is requested while any handler is active. With nesting on, only a strictly higher-priority source can preempt.

The first `NUM_EXT` sources are asynchronous external lines. Each has a two-flop synchroniser, and software chooses per line whether it is level or edge sensitive. The remaining sources are synchronous internal lines whose sensitivity is fixed at build time by a parameter. Software programs the block through a write-only register port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req_o` is low and all of the following are cleared: pending latches, enables, in-service bits, vectors, the nesting mode and the external edge selects.
- R2: A write with `reg_we_i` high acts according to `reg_addr_i`:
  - Address 0: bit 0 sets the nesting mode, and bits [NUM_EXT:1] select edge (1) or level (0) for external lines 0..NUM_EXT-1.
  - Address 1: loads the enable mask, with bit i enabling source i.
  - Address 2: sets pending latches.
  - Address 3: clears pending latches.
  - Address 16+i: loads the VEC_W-bit vector of source i.
- R3: A source takes part in arbitration only while it is latched, enabled and not in service. `irq_id_o` and `irq_vec_o` show the lowest-numbered such source and its vector. An enable written to 0 only hides a latched edge request; the latch is kept.
- R4: An external line in edge mode sets its latch on a synchronised rising edge. The request appears after the third rising clock edge following the input change, and not after the second. A line held high latches only once.
- R5: A level-sensitive latch mirrors its input. For external lines this is the synchronised input, with a three-clock delay. For internal lines it is the input registered once. Dropping the input withdraws the request.
- R6: With nesting off, no request is raised while any in-service bit is set.
- R7: With nesting on, a request is raised while handlers are active only if the winning source has a lower index than every in-service source.
- R8: An acknowledge while `irq_req_o` is high sets the in-service bit of the presented source. If that source is edge sensitive, its latch is cleared in the same cycle, and this clear beats any set in that cycle.
- R9: A return-from-interrupt clears the lowest-numbered in-service bit.
- R10: The latch-set and latch-clear writes affect only edge-sensitive sources. Level-sensitive latches keep following their inputs.
- R11: Internal source i (index NUM_EXT and up) is edge sensitive when bit i of `FIXED_EDGE` is 1 and level sensitive otherwise. Its edge is sampled without synchronisation, so it latches one clock after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | NUM_EXT | Asynchronous external request lines (sources 0..NUM_EXT-1) |
| int_irq_i | input | NUM_SRC-NUM_EXT | Synchronous internal request lines (sources NUM_EXT and up) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register write address |
| reg_wdata_i | input | DATA_W | Register write data |
| irq_ack_i | input | 1 | Core accepts the presented request |
| irq_rti_i | input | 1 | Core returns from the current handler |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | ID_W | Index of the presented source |
| irq_vec_o | output | VEC_W | Vector of the presented source |

## Verification
The hardest state to reach from the ports has two handlers active at once in nested mode. A lower-priority level source is acknowledged first, and a fresh external edge then preempts it. A return must then retire only the inner handler, while the pre-empted one keeps all requests suppressed until a second return. The directed sequence builds this state deliberately: it holds an internal level line high, acknowledges it, and then pulses an external edge line, checking the request on the exact clocks the synchroniser dictates. The constrained-random phase then mixes random enables, level patterns and nesting modes with acknowledge and return cycles, and compares the result against a priority function in the bench.

// File: rtl/irq_vic_pkg.sv
package irq_vic_pkg;
  localparam int unsigned ADDR_MODE     = 0;
  localparam int unsigned ADDR_MASK     = 1;
  localparam int unsigned ADDR_LSET     = 2;
  localparam int unsigned ADDR_LCLR     = 3;
  localparam int unsigned ADDR_VEC_BASE = 16;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import irq_vic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_EXT = 4,
  parameter int VEC_W   = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic                            nested_o,
  output logic [NUM_EXT-1:0]              ext_edge_o,
  output logic [NUM_SRC-1:0]              mask_o,
  output logic [NUM_SRC-1:0]              sw_set_o,
  output logic [NUM_SRC-1:0]              sw_clr_o,
  output logic [NUM_SRC-1:0][VEC_W-1:0]   vec_o
);
  logic                 nested_q;
  logic [NUM_EXT-1:0]   ext_edge_q;
  logic [NUM_SRC-1:0]   mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nested_q   <= 1'b0;
      ext_edge_q <= '0;
      mask_q     <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(ADDR_MODE)) begin
        nested_q   <= wdata_i[0];
        ext_edge_q <= wdata_i[NUM_EXT:1];
      end
      if (addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wdata_i[NUM_SRC-1:0];
    end
  end

  // one-cycle strobes into the latch bank
  assign sw_set_o = (we_i && addr_i == ADDR_W'(ADDR_LSET)) ? wdata_i[NUM_SRC-1:0] : '0;
  assign sw_clr_o = (we_i && addr_i == ADDR_W'(ADDR_LCLR)) ? wdata_i[NUM_SRC-1:0] : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_vec
    logic [VEC_W-1:0] vec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          vec_q <= '0;
      else if (we_i && addr_i == ADDR_W'(ADDR_VEC_BASE + i)) vec_q <= wdata_i[VEC_W-1:0];
    end
    assign vec_o[i] = vec_q;
  end

  assign nested_o   = nested_q;
  assign ext_edge_o = ext_edge_q;
  assign mask_o     = mask_q;
endmodule

// File: rtl/vic_latch.sv
module vic_latch #(
  parameter int               NUM_SRC    = 8,
  parameter int               NUM_EXT    = 4,
  parameter logic [NUM_SRC-1:0] FIXED_EDGE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_EXT-1:0] ext_edge_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  input  logic [NUM_SRC-1:0] ack_clr_i,
  output logic [NUM_SRC-1:0] edge_sel_o,
  output logic [NUM_SRC-1:0] latch_o
);
  logic [NUM_SRC-1:0] prev_q, latch_q, rise;
  logic               past_ok_q;

  assign edge_sel_o = {FIXED_EDGE[NUM_SRC-1:NUM_EXT], ext_edge_i};
  assign rise       = src_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      past_ok_q <= 1'b0;
    end else begin
      prev_q    <= src_i;
      past_ok_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            latch_q[i] <= 1'b0;
      else if (edge_sel_o[i]) latch_q[i] <= (latch_q[i] | rise[i] | sw_set_i[i])
                                            & ~sw_clr_i[i] & ~ack_clr_i[i];
      else                    latch_q[i] <= src_i[i];
    end

    // R5
    level_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok_q && !edge_sel_o[i] && !$past(edge_sel_o[i]) |-> latch_q[i] == $past(src_i[i]));
    // R8
    ack_clears_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_clr_i[i] && edge_sel_o[i] |=> !latch_q[i]);
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NUM_SRC = 8,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] latch_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               nested_i,
  input  logic               ack_i,
  input  logic               rti_i,
  output logic               req_o,
  output logic [ID_W-1:0]    id_o,
  output logic [NUM_SRC-1:0] ack_hit_o,
  output logic [NUM_SRC-1:0] isr_o
);
  logic [NUM_SRC-1:0] isr_q, pend, rti_hit;
  logic               found, busy;
  logic [ID_W-1:0]    win_id, busy_id;

  assign pend = latch_i & mask_i & ~isr_q;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    found   = 1'b0;
    win_id  = '0;
    busy    = 1'b0;
    busy_id = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i])  begin found = 1'b1; win_id  = ID_W'(i); end
      if (isr_q[i]) begin busy  = 1'b1; busy_id = ID_W'(i); end
    end
  end

  assign req_o = found && (!busy || (nested_i && win_id < busy_id));
  assign id_o  = win_id;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign ack_hit_o[i] = ack_i && req_o && (win_id == ID_W'(i));
    assign rti_hit[i]   = rti_i && busy && (busy_id == ID_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~rti_hit) | ack_hit_o;
  end

  assign isr_o = isr_q;

  // R6
  flat_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !nested_i |-> isr_q == '0);
  // R8
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && req_o |=> isr_q[$past(id_o)]);
  // R9
  rti_retires_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i && !ack_i && isr_q != '0 |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int                 NUM_SRC    = 8,
  parameter int                 NUM_EXT    = 4,
  parameter int                 VEC_W      = 16,
  parameter int                 ADDR_W     = 5,
  parameter int                 DATA_W     = 32,
  parameter logic [NUM_SRC-1:0] FIXED_EDGE = 8'hA0,
  localparam int                ID_W       = $clog2(NUM_SRC),
  localparam int                NUM_INT    = NUM_SRC - NUM_EXT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_INT-1:0] int_irq_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic               irq_ack_i,
  input  logic               irq_rti_i,
  output logic               irq_req_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic [VEC_W-1:0]   irq_vec_o
);
  logic                          nested;
  logic [NUM_EXT-1:0]            ext_edge, ext_sync;
  logic [NUM_SRC-1:0]            mask, sw_set, sw_clr, latch, edge_sel, ack_hit, isr;
  logic [NUM_SRC-1:0][VEC_W-1:0] vec_tab;

  vic_sync #(.W(NUM_EXT)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ext_irq_i), .q_o (ext_sync)
  );

  vic_regs #(
    .NUM_SRC (NUM_SRC), .NUM_EXT (NUM_EXT), .VEC_W (VEC_W),
    .ADDR_W (ADDR_W), .DATA_W (DATA_W)
  ) u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (reg_we_i), .addr_i (reg_addr_i),
    .wdata_i (reg_wdata_i), .nested_o (nested), .ext_edge_o (ext_edge),
    .mask_o (mask), .sw_set_o (sw_set), .sw_clr_o (sw_clr), .vec_o (vec_tab)
  );

  vic_latch #(
    .NUM_SRC (NUM_SRC), .NUM_EXT (NUM_EXT), .FIXED_EDGE (FIXED_EDGE)
  ) u_latch (
    .clk_i (clk_i), .rst_ni (rst_ni), .src_i ({int_irq_i, ext_sync}),
    .ext_edge_i (ext_edge), .sw_set_i (sw_set), .sw_clr_i (sw_clr),
    .ack_clr_i (ack_hit), .edge_sel_o (edge_sel), .latch_o (latch)
  );

  vic_arb #(.NUM_SRC (NUM_SRC)) u_arb (
    .clk_i (clk_i), .rst_ni (rst_ni), .latch_i (latch), .mask_i (mask),
    .nested_i (nested), .ack_i (irq_ack_i), .rti_i (irq_rti_i),
    .req_o (irq_req_o), .id_o (irq_id_o), .ack_hit_o (ack_hit), .isr_o (isr)
  );

  assign irq_vec_o = vec_tab[irq_id_o];

  // R3
  winner_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> latch[irq_id_o] && mask[irq_id_o] && !isr[irq_id_o]);
  // R10
  level_sw_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set & ~edge_sel) != '0 |=> (latch & $past(sw_set & ~edge_sel)) == ($past({int_irq_i, ext_sync}) & $past(sw_set & ~edge_sel)));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int NS = 8;
  localparam int NE = 4;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NE-1:0] ext = '0;
  logic [NS-NE-1:0] intr = '0;
  logic          we = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          ack = 1'b0, rti = 1'b0;
  logic          req;
  logic [2:0]    id;
  logic [VW-1:0] vec;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .ext_irq_i (ext), .int_irq_i (intr),
    .reg_we_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .irq_ack_i (ack), .irq_rti_i (rti),
    .irq_req_o (req), .irq_id_o (id), .irq_vec_o (vec)
  );

  function automatic logic [VW-1:0] exp_vec(int i);
    return VW'(16'h0100 + i * 16);
  endfunction

  function automatic int lowest(logic [NS-1:0] p);
    for (int i = 0; i < NS; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_win(string tag, int src);
    check({tag, " req"}, 32'(req), 32'd1);
    check({tag, " id"}, 32'(id), 32'(src));
    check({tag, " vec"}, 32'(vec), 32'(exp_vec(src)));
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    we = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_ack;
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_rti;
    rti = 1'b1; @(negedge clk); rti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    check("R1 reset req", 32'(req), 0);

    // level internal src6 high but mask reset to zero
    intr[2] = 1'b1;
    tick(3);
    check("R1 mask cleared", 32'(req), 0);

    for (int i = 0; i < NS; i++) wr(16 + i, 32'(exp_vec(i)));
    wr(0, 32'h6);           // flat mode; ext0,1 edge, ext2,3 level
    wr(1, 32'hFF);
    tick(1);
    chk_win("R2 R3 R5 level int", 6);

    intr[0] = 1'b1;         // src4 level
    tick(2);
    chk_win("R3 priority", 4);
    wr(1, 32'hEF);
    chk_win("R3 masked out", 6);
    intr[0] = 1'b0;
    wr(1, 32'hFF);
    tick(1);

    do_ack;
    check("R8 ack drops req", 32'(req), 0);
    ext[0] = 1'b1; tick(1); ext[0] = 1'b0;
    tick(4);
    check("R6 flat blocks", 32'(req), 0);
    do_rti;
    chk_win("R9 R4 edge held", 0);

    wr(0, 32'h7);           // nested
    do_ack;
    check("R7 lower prio blocked", 32'(req), 0);
    do_rti;
    chk_win("R9 resume src6", 6);
    do_ack;
    check("R8 src6 in service", 32'(req), 0);
    ext[1] = 1'b1;
    tick(2);
    check("R4 not after two clocks", 32'(req), 0);
    tick(1);
    chk_win("R4 R7 preempt", 1);
    ext[1] = 1'b0;
    do_ack;
    check("R7 both active", 32'(req), 0);
    do_rti;
    check("R9 R8 inner retired", 32'(req), 0);
    intr[2] = 1'b0;
    do_rti;
    tick(2);
    check("R5 level withdrawn", 32'(req), 0);

    ext[2] = 1'b1;
    tick(3);
    chk_win("R5 ext level", 2);
    ext[2] = 1'b0;
    tick(2);
    check("R5 ext level delay", 32'(req), 1);
    tick(1);
    check("R5 ext level drop", 32'(req), 0);

    ext[0] = 1'b1;
    tick(4);
    chk_win("R4 held edge", 0);
    do_ack; do_rti;
    tick(3);
    check("R4 single latch", 32'(req), 0);
    ext[0] = 1'b0;
    tick(3);

    wr(2, 32'h20);
    chk_win("R10 sw set", 5);
    wr(3, 32'h20);
    check("R10 sw clear", 32'(req), 0);
    wr(2, 32'h40);
    tick(1);
    check("R10 level ignores set", 32'(req), 0);

    intr[3] = 1'b1;
    tick(1);
    chk_win("R11 int edge", 7);
    do_ack; do_rti;
    tick(2);
    check("R11 no retrigger", 32'(req), 0);
    intr[3] = 1'b0;

    wr(1, 32'hDF);
    intr[1] = 1'b1; tick(1); intr[1] = 1'b0;
    tick(2);
    check("R3 masked edge hidden", 32'(req), 0);
    wr(1, 32'hFF);
    chk_win("R3 latch kept", 5);
    do_ack; do_rti;
    tick(2);

    for (int k = 0; k < 80; k++) begin
      logic [31:0] m, lv;
      logic [NS-1:0] pend;
      int e;
      m  = $urandom;
      lv = $urandom;
      wr(0, 32'h6 | 32'(lv[4]));
      ext[2] = lv[0]; ext[3] = lv[1]; intr[0] = lv[2]; intr[2] = lv[3];
      wr(1, m);
      tick(4);
      pend = {1'b0, lv[3], 1'b0, lv[2], lv[1], lv[0], 2'b00} & m[NS-1:0];
      e = lowest(pend);
      if (e < 0) check("R3 random idle", 32'(req), 0);
      else begin
        chk_win("R3 random", e);
        do_ack;
        check("R6 R7 random ack", 32'(req), 0);
        do_rti;
        chk_win("R9 random rti", e);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule